// File: doc/BRIEF.md
# Per-Target Address Decode with Selectable Latency

This block sits on a multiplexed address/data bus and turns each address phase into one chip select for one of three downstream targets: a register controller, a static memory controller and a DRAM controller. The address is taken from the bus on every clock edge at which the address strobe is high. The captured address is then compared against one fixed window per target.

A three-bit timing register picks the decode latency separately for each target. With a target's bit clear, that target's select follows the captured address with no extra clock. This suits slow bus clocks. With the bit set, the select waits one more clock edge. This gives fast systems a full cycle of setup before the target acts on the select. The register controller and the memory controller start in the delayed setting. The DRAM controller starts in the undelayed setting; its delay is meant for bus clocks above 75 MHz. A select stays asserted while the transaction-in-progress input is high. It falls after the first edge at which that input is low. An address outside every window asserts no select and produces a one-cycle no-decode pulse instead.

Top module: `addr_decode_pipe`

## Requirements
- R1: When a target's timing bit is 1 at the capture edge, that target's select is low after the capture edge. It goes high only after the next rising edge, provided `xfer_active` is high at that edge.
- R2: When a target's timing bit is 0 at the capture edge, that target's select is high immediately after the capture edge.
- R3: The timing register bits map to targets as follows: bit 0 is the register controller, bit 1 is the static memory controller and bit 2 is the DRAM controller. A write with `cfg_we` high loads `cfg_wdata[2:0]`, and `cfg_rdata[2:0]` returns the stored bits.
- R4: After reset, `cfg_rdata` reads 3 (binary 011), and all selects and `no_decode` are low.
- R5: `cfg_rdata[31:3]` always reads zero, whatever value was written.
- R6: Each address phase uses the timing bits held in the register at its capture edge. A write on that same edge, or any later write during the phase, takes effect only from the next address phase.
- R7: The windows are fixed. The register controller covers 0x1800_0000 to 0x1800_FFFF. The memory controller covers 0x1000_0000 to 0x10FF_FFFF. The DRAM controller covers 0x0000_0000 to 0x07FF_FFFF. At most one select is high in any cycle.
- R8: An address phase whose address lies in no window asserts no select and raises `no_decode` for exactly one cycle, right after the capture edge.
- R9: The address is captured at every rising edge at which `ale` is high. A select stays at a constant value for the whole phase. All selects are low after the first edge at which `ale` is low and `xfer_active` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 32 | Multiplexed address/data bus |
| ale | input | 1 | Address strobe, active high |
| xfer_active | input | 1 | Transaction in progress, active high |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 32 | Timing register write data |
| cfg_rdata | output | 32 | Timing register contents, upper bits zero |
| sel_reg | output | 1 | Select for the register controller |
| sel_mem | output | 1 | Select for the static memory controller |
| sel_dram | output | 1 | Select for the DRAM controller |
| no_decode | output | 1 | One-cycle pulse for an address in no window |

## Verification
A timing-register write and an address capture can land on the same clock edge. That is the case where a new latency could leak into the phase already under way. The bench drives `cfg_we` on the very edge at which `ale` is high. It then expects the select latency to follow the old setting and the next phase to follow the new one. A second case writes in the middle of a phase, after the select has already asserted. There the bench requires the select to stay constant until the transaction ends. A scoreboard queue records the expected target, latency and no-decode flag for each phase, and judges them against what the outputs showed.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int unsigned NUM_TGT = 3;
  localparam int unsigned SPAN_W  = 6;

  typedef enum int unsigned {
    TGT_REG  = 0,
    TGT_MEM  = 1,
    TGT_DRAM = 2
  } tgt_e;
endpackage

// File: rtl/adp_addr_latch.sv
module adp_addr_latch #(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic             xfer_active,
  input  logic [BUS_W-1:0] bus_ad,
  output logic [BUS_W-1:0] addr_q,
  output logic             ale_q,
  output logic             active_q,
  output logic             stage2_q
);
  logic [BUS_W-1:0] addr_d;
  logic             active_d;
  logic             stage2_d;

  always_comb begin
    addr_d   = addr_q;
    active_d = active_q & xfer_active;
    stage2_d = active_q & xfer_active;
    if (ale) begin
      addr_d   = bus_ad;
      active_d = 1'b1;
      stage2_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      ale_q    <= 1'b0;
      active_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      ale_q    <= ale;
      active_q <= active_d;
      stage2_q <= stage2_d;
    end
  end
endmodule

// File: rtl/adp_window_match.sv
module adp_window_match import adp_pkg::*; #(
  parameter int unsigned               BUS_W    = 32,
  parameter logic [NUM_TGT*BUS_W-1:0]  WIN_BASE = '0,
  parameter logic [NUM_TGT*SPAN_W-1:0] WIN_SPAN = '0
) (
  input  logic [BUS_W-1:0]   addr,
  output logic [NUM_TGT-1:0] hit
);
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_win
    localparam logic [BUS_W-1:0] BASE  = WIN_BASE[g*BUS_W +: BUS_W];
    localparam int unsigned      SHIFT = int'(WIN_SPAN[g*SPAN_W +: SPAN_W]);
    assign hit[g] = (addr >> SHIFT) == (BASE >> SHIFT);
  end
endmodule

// File: rtl/adp_timing_reg.sv
module adp_timing_reg import adp_pkg::*; #(
  parameter int unsigned         BUS_W      = 32,
  parameter logic [NUM_TGT-1:0]  TIMING_RST = 3'b011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [BUS_W-1:0]   cfg_wdata,
  output logic [NUM_TGT-1:0] timing_q,
  output logic [BUS_W-1:0]   cfg_rdata
);
  localparam int unsigned PAD_W = BUS_W - NUM_TGT;

  logic [NUM_TGT-1:0] timing_d;
  logic [PAD_W-1:0]   unused_wdata;

  assign unused_wdata = cfg_wdata[BUS_W-1:NUM_TGT];

  always_comb begin
    timing_d = timing_q;
    if (cfg_we) timing_d = cfg_wdata[NUM_TGT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timing_q <= TIMING_RST;
    else        timing_q <= timing_d;
  end

  assign cfg_rdata = {{PAD_W{1'b0}}, timing_q};
endmodule

// File: rtl/adp_sel_stage.sv
module adp_sel_stage import adp_pkg::*; #(
  parameter logic [NUM_TGT-1:0] TIMING_RST = 3'b011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ale,
  input  logic               ale_q,
  input  logic [NUM_TGT-1:0] timing_q,
  input  logic [NUM_TGT-1:0] hit_q,
  input  logic [NUM_TGT-1:0] hit_bus,
  input  logic               active_q,
  input  logic               stage2_q,
  output logic [NUM_TGT-1:0] sel,
  output logic               no_decode
);
  logic [NUM_TGT-1:0] mode_q, mode_d;
  logic               nodec_q, nodec_d;

  always_comb begin
    mode_d  = mode_q;
    if (ale) mode_d = timing_q;
    nodec_d = ale & ~ale_q & ~(|hit_bus);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TIMING_RST;
      nodec_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      nodec_q <= nodec_d;
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
    assign sel[g] = active_q & hit_q[g] & (mode_q[g] ? stage2_q : 1'b1);
  end

  assign no_decode = nodec_q;
endmodule

// File: rtl/addr_decode_pipe.sv
module addr_decode_pipe import adp_pkg::*; #(
  parameter int unsigned               BUS_W      = 32,
  parameter logic [NUM_TGT*BUS_W-1:0]  WIN_BASE   = {32'h0000_0000, 32'h1000_0000, 32'h1800_0000},
  parameter logic [NUM_TGT*SPAN_W-1:0] WIN_SPAN   = {6'd27, 6'd24, 6'd16},
  parameter logic [NUM_TGT-1:0]        TIMING_RST = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_ad,
  input  logic             ale,
  input  logic             xfer_active,
  input  logic             cfg_we,
  input  logic [BUS_W-1:0] cfg_wdata,
  output logic [BUS_W-1:0] cfg_rdata,
  output logic             sel_reg,
  output logic             sel_mem,
  output logic             sel_dram,
  output logic             no_decode
);
  logic [BUS_W-1:0]   addr_q;
  logic               ale_q, active_q, stage2_q;
  logic [NUM_TGT-1:0] hit_q, hit_bus, timing_q, sel;

  adp_addr_latch #(.BUS_W(BUS_W)) i_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .xfer_active(xfer_active),
    .bus_ad(bus_ad), .addr_q(addr_q), .ale_q(ale_q),
    .active_q(active_q), .stage2_q(stage2_q)
  );

  adp_window_match #(.BUS_W(BUS_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)) i_match_q (
    .addr(addr_q), .hit(hit_q)
  );

  adp_window_match #(.BUS_W(BUS_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)) i_match_bus (
    .addr(bus_ad), .hit(hit_bus)
  );

  adp_timing_reg #(.BUS_W(BUS_W), .TIMING_RST(TIMING_RST)) i_treg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .timing_q(timing_q), .cfg_rdata(cfg_rdata)
  );

  adp_sel_stage #(.TIMING_RST(TIMING_RST)) i_sel (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ale_q(ale_q), .timing_q(timing_q),
    .hit_q(hit_q), .hit_bus(hit_bus), .active_q(active_q), .stage2_q(stage2_q),
    .sel(sel), .no_decode(no_decode)
  );

  assign sel_reg  = sel[TGT_REG];
  assign sel_mem  = sel[TGT_MEM];
  assign sel_dram = sel[TGT_DRAM];
endmodule

// File: rtl/adp_checker.sv
module adp_checker import adp_pkg::*; #(
  parameter int unsigned               BUS_W    = 32,
  parameter logic [NUM_TGT*BUS_W-1:0]  WIN_BASE = '0,
  parameter logic [NUM_TGT*SPAN_W-1:0] WIN_SPAN = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] bus_ad,
  input logic             ale,
  input logic             xfer_active,
  input logic [BUS_W-1:0] cfg_rdata,
  input logic             sel_reg,
  input logic             sel_mem,
  input logic             sel_dram,
  input logic             no_decode
);
  localparam int unsigned SH_R = int'(WIN_SPAN[0 +: SPAN_W]);
  localparam int unsigned SH_D = int'(WIN_SPAN[2*SPAN_W +: SPAN_W]);
  localparam logic [BUS_W-1:0] B_R = WIN_BASE[0 +: BUS_W];
  localparam logic [BUS_W-1:0] B_D = WIN_BASE[2*BUS_W +: BUS_W];

  logic in_reg_win, in_dram_win;
  assign in_reg_win  = (bus_ad >> SH_R) == (B_R >> SH_R);
  assign in_dram_win = (bus_ad >> SH_D) == (B_D >> SH_D);

  a_r1_reg_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && cfg_rdata[0]) |=> !sel_reg);
  a_r1_mem_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && cfg_rdata[1]) |=> !sel_mem);
  a_r1_dram_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && cfg_rdata[2]) |=> !sel_dram);

  a_r2_reg_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !cfg_rdata[0] && in_reg_win) |=> sel_reg);
  a_r2_dram_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !cfg_rdata[2] && in_dram_win) |=> sel_dram);

  a_r7_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_reg, sel_mem, sel_dram}));

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    no_decode |=> !no_decode);

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !xfer_active) |=> !(sel_reg || sel_mem || sel_dram));

  always @(posedge clk) begin
    if (rst_n) begin
      a_r5_rsvd_zero: assert (cfg_rdata[BUS_W-1:NUM_TGT] == '0);
    end
  end
endmodule

bind addr_decode_pipe adp_checker #(
  .BUS_W(BUS_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)
) i_adp_checker (
  .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .ale(ale),
  .xfer_active(xfer_active), .cfg_rdata(cfg_rdata), .sel_reg(sel_reg),
  .sel_mem(sel_mem), .sel_dram(sel_dram), .no_decode(no_decode)
);

// File: tb/test_addr_decode_pipe.sv
module test_addr_decode_pipe;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0] tgt;
    int         lat;
    bit         nd;
  } exp_t;

  logic        clk, rst_n, ale, xfer_active, cfg_we;
  logic [31:0] bus_ad, cfg_wdata, cfg_rdata;
  logic        sel_reg, sel_mem, sel_dram, no_decode;

  int   checks, failures;
  logic [2:0] cfg_model;
  exp_t exp_q[$];

  addr_decode_pipe i_addr_decode_pipe (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .ale(ale),
    .xfer_active(xfer_active), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sel_reg(sel_reg), .sel_mem(sel_mem),
    .sel_dram(sel_dram), .no_decode(no_decode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] tgt_of(input logic [31:0] a);
    if (a >= 32'h1800_0000 && a <= 32'h1800_FFFF) return 3'b001;
    if (a >= 32'h1000_0000 && a <= 32'h10FF_FFFF) return 3'b010;
    if (a <= 32'h07FF_FFFF)                       return 3'b100;
    return 3'b000;
  endfunction

  // monitor: posedge sampling of strobes, negedge sampling of outputs
  logic p_ale, p_xfer;
  always @(posedge clk) begin
    p_ale  = ale;
    p_xfer = xfer_active;
  end

  bit         in_phase;
  int         cnt, seen_lat;
  logic [2:0] seen_sel;
  bit         seen_nd, unstable;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] s;
      s = {sel_dram, sel_mem, sel_reg};
      if (p_ale) begin
        in_phase = 1; cnt = 1; seen_lat = 0; seen_sel = 0;
        seen_nd = no_decode; unstable = 0;
      end else if (in_phase) begin
        cnt++;
        if (no_decode) seen_nd = 0;
      end
      if (in_phase) begin
        if (!p_xfer && !p_ale) begin
          exp_t e;
          chk("R9 selects low after xfer end", {29'd0, s}, 32'd0);
          if (exp_q.size() == 0) begin
            chk("R9 scoreboard has item", 32'd0, 32'd1);
          end else begin
            e = exp_q.pop_front();
            chk(e.lat == 2 ? "R1 delayed latency" : (e.lat == 1 ? "R2 fast latency" : "R8 no select"),
                seen_lat, e.lat);
            chk("R7 selected target", {29'd0, seen_sel}, {29'd0, e.tgt});
            chk("R8 no_decode single pulse", {31'd0, seen_nd}, {31'd0, e.nd});
            chk("R9 select stable in phase", {31'd0, unstable}, 32'd0);
          end
          in_phase = 0;
        end else if (seen_lat == 0 && s != 0) begin
          seen_lat = cnt;
          seen_sel = s;
        end else if (seen_lat != 0 && s != seen_sel) begin
          unstable = 1;
        end
      end
    end
  end

  task automatic write_cfg(input logic [31:0] v, input logic [2:0] exp_rd);
    @(negedge clk); #1;
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk); #1;
    cfg_we = 0;
    cfg_model = v[2:0];
    chk("R3 readback", cfg_rdata, {29'd0, exp_rd});
  endtask

  task automatic run_phase(input logic [31:0] a, input int hold,
                           input bit wr_cap, input bit wr_mid, input logic [31:0] wv);
    exp_t e;
    logic [2:0] t;
    t = tgt_of(a);
    e.tgt = t;
    e.nd  = (t == 0);
    e.lat = (t == 0) ? 0 : (((cfg_model & t) != 0) ? 2 : 1);
    @(negedge clk); #1;
    ale = 1; xfer_active = 1; bus_ad = a;
    if (wr_cap) begin cfg_we = 1; cfg_wdata = wv; end
    exp_q.push_back(e);
    @(negedge clk); #1;
    ale = 0; bus_ad = ~a;
    if (wr_cap) begin cfg_we = 0; cfg_model = wv[2:0]; end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); #1;
      if (wr_mid && i == 1) begin cfg_we = 1; cfg_wdata = wv; end
      if (wr_mid && i == 2) begin cfg_we = 0; cfg_model = wv[2:0]; end
    end
    xfer_active = 0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  bit done;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0; in_phase = 0;
    rst_n = 0; ale = 0; xfer_active = 0; cfg_we = 0;
    bus_ad = '0; cfg_wdata = '0; cfg_model = 3'b011;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R4 reset timing value", cfg_rdata, 32'd3);
    chk("R4 reset selects", {28'd0, sel_dram, sel_mem, sel_reg, no_decode}, 32'd0);
    #1;

    // defaults: register and memory delayed, DRAM fast
    run_phase(32'h1800_0040, 4, 0, 0, 0);
    run_phase(32'h1000_0000, 4, 0, 0, 0);
    run_phase(32'h0000_1000, 4, 0, 0, 0);
    run_phase(32'h0800_0000, 4, 0, 0, 0);   // R8 just past DRAM
    run_phase(32'h1801_0000, 4, 0, 0, 0);   // R8 just past register window
    run_phase(32'h2000_0000, 3, 0, 0, 0);

    // R3 bit mapping: only DRAM delayed
    write_cfg(32'h0000_0004, 3'b100);
    run_phase(32'h1800_FFFC, 4, 0, 0, 0);
    run_phase(32'h10FF_FFF0, 4, 0, 0, 0);
    run_phase(32'h07FF_FFFC, 4, 0, 0, 0);

    // R5 reserved bits read zero
    write_cfg(32'hFFFF_FFF8, 3'b000);
    chk("R5 reserved bits zero", cfg_rdata & 32'hFFFF_FFF8, 32'd0);
    run_phase(32'h1000_0100, 4, 0, 0, 0);
    write_cfg(32'hFFFF_FFFF, 3'b111);
    chk("R5 all-ones write", cfg_rdata, 32'd7);
    run_phase(32'h0000_0000, 4, 0, 0, 0);

    // R6 write on the capture edge: old setting this phase, new next phase
    run_phase(32'h1000_2000, 4, 1, 0, 32'h0000_0000);
    chk("R6 write landed", cfg_rdata, 32'd0);
    run_phase(32'h1000_2000, 4, 0, 0, 0);

    // R6 write mid-phase leaves the running phase alone
    run_phase(32'h1800_0010, 6, 0, 1, 32'h0000_0007);
    run_phase(32'h1800_0010, 4, 0, 0, 0);

    repeat (4) @(negedge clk);
    chk("R9 all phases judged", exp_q.size(), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule